// File: doc/BRIEF.md
# Slave-Side Burst Progress Tracker

This block sits beside a bus slave port and watches the transfer type, the burst code, the transfer size and the address that the master presents. It follows each burst beat by beat. It shows whether a burst is in progress, how many beats have been accepted, and the address that the next sequential beat must carry. It raises a one-cycle pulse when a fixed-length burst finishes normally. It raises a different one-cycle pulse when a fixed-length burst is cut short by a new burst or by an idle transfer. A sequential beat whose address differs from the expected one raises a one-cycle error flag.

A slave that prefetches data or buffers writes uses these outputs to decide how far ahead it may work, and when to drop work that belongs to a burst that was abandoned. The slave's own storage is not part of this block.

The controller has three states. `ST_OFF` means no burst is open. `ST_FIX` means a burst of 4, 8 or 16 beats is open. `ST_OPEN` means a burst of unspecified length is open. The transitions are:
- *launch*: a new-burst beat moves from any state to `ST_FIX` or `ST_OPEN`. A single-transfer code moves to `ST_OFF` instead.
- *finish*: the last beat of a fixed burst moves `ST_FIX` to `ST_OFF`.
- *abandon*: an idle transfer moves `ST_FIX` or `ST_OPEN` to `ST_OFF`.
- *preempt*: a new-burst beat arriving in `ST_FIX` or `ST_OPEN` starts the new burst at once.

Top module: `burst_tracker`

## Requirements
- R1: After reset, `active_o` is 0, `beats_o` is 0, `next_addr_o` is 0, and `done_o`, `cut_o` and `err_o` are 0.
- R2: A cycle is sampled only when `sel_i` and `ready_i` are both 1. A sampled busy cycle (`trans_i` = 01) changes no output and leaves every pulse low. So does a cycle with `sel_i` = 0 or `ready_i` = 0.
- R3: A sampled new-burst beat (`trans_i` = 10) sets `beats_o` to 1 on the next cycle. For every burst code except 000 it also sets `active_o`. The burst code (`burst_i`) is decoded as follows: 000 single, 001 unspecified-length incrementing, 010/100/110 wrapping of 4/8/16 beats, and 011/101/111 incrementing of 4/8/16 beats.
- R4: For incrementing and unspecified-length bursts, `next_addr_o` after each accepted beat equals the previous expected address plus 2^`size_i`. For a new-burst beat, the previous expected address is `addr_i`.
- R5: For wrapping bursts, `next_addr_o` stays inside the aligned block of (beats × 2^size) bytes. When the step would leave the block, it wraps to the block's lowest address.
- R6: `done_o` pulses for one cycle after the final beat of a fixed-length burst is accepted, and `active_o` falls in the same cycle. A single transfer (code 000) counts as a fixed burst of length 1.
- R7: `cut_o` pulses for one cycle when a new-burst or idle transfer is sampled while a 4/8/16-beat burst has accepted fewer beats than its length.
- R8: An unspecified-length burst never raises `done_o` or `cut_o`. It may hold any number of beats, including one. It ends on a sampled idle or new-burst transfer.
- R9: A sampled sequential beat (`trans_i` = 11) raises `err_o` for one cycle in two cases: when its `addr_i` differs from `next_addr_o`, and when no burst is open. Inside a burst, the beat is still counted and the expected address advances from the expected value. Outside a burst, it changes nothing else.
- R10: A sampled idle transfer (`trans_i` = 00) clears `beats_o` and `active_o` on the next cycle.
- R11: `beats_o` saturates at its maximum value during a long unspecified-length burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 1 | Slave selected |
| ready_i | input | 1 | Bus ready; a transfer is sampled only when high |
| trans_i | input | 2 | Transfer type: 00 idle, 01 busy, 10 new burst, 11 sequential |
| burst_i | input | 3 | Burst code |
| size_i | input | 3 | log2 of bytes per beat |
| addr_i | input | ADDR_W | Transfer address |
| active_o | output | 1 | A burst is open |
| beats_o | output | CNT_W | Beats accepted in the current or last burst |
| next_addr_o | output | ADDR_W | Address expected for the next sequential beat |
| done_o | output | 1 | One-cycle pulse: fixed burst finished |
| cut_o | output | 1 | One-cycle pulse: fixed burst terminated early |
| err_o | output | 1 | One-cycle pulse: sequential beat with a bad address, or outside a burst |

## Verification
Every result is registered, so each output reflects the sampled cycle one clock edge later. `active_o`, `beats_o` and `next_addr_o` then hold their values. `done_o`, `cut_o` and `err_o` stay high for exactly that one cycle.

The bench drives inputs on the falling edge. It advances a reference model of its own for the sampled cycle, waits past the next rising edge, and compares all six outputs there. As a result, every pulse is caught in the single cycle in which it is due, and any stray pulse in the cycles around it is also caught.

The sweeps cover:
- every burst code at three sizes and three start addresses, with and without busy, wait and deselected cycles;
- termination after every beat position of every fixed burst;
- unspecified-length bursts of one to four beats.

// File: rtl/bt_pkg.sv
package bt_pkg;

    typedef enum logic [1:0] {
        TT_IDLE = 2'b00,
        TT_BUSY = 2'b01,
        TT_NSEQ = 2'b10,
        TT_SEQ  = 2'b11
    } xfer_t;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_FIX  = 2'd1,
        ST_OPEN = 2'd2
    } trk_state_t;

    typedef struct packed {
        logic       fixed;    // known length (single or 4/8/16)
        logic       wrap;     // wrapping address pattern
        logic [2:0] len_log;  // log2 of the beat count for fixed bursts
    } burst_info_t;

endpackage

// File: rtl/bt_decode.sv
module bt_decode
    import bt_pkg::*;
(
    input  logic [2:0]  code_i,
    output burst_info_t info_o
);

    always_comb begin
        info_o = '0;
        unique case (code_i)
            3'b000: begin
                info_o.fixed   = 1'b1;
                info_o.wrap    = 1'b0;
                info_o.len_log = 3'd0;
            end
            3'b001: begin
                info_o.fixed   = 1'b0;
                info_o.wrap    = 1'b0;
                info_o.len_log = 3'd0;
            end
            default: begin
                info_o.fixed   = 1'b1;
                info_o.wrap    = ~code_i[0];
                info_o.len_log = {1'b0, code_i[2:1]} + 3'd1;
            end
        endcase
    end

endmodule

// File: rtl/bt_next_addr.sv
module bt_next_addr #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur_i,
    input  logic [2:0]        size_i,
    input  logic              wrap_i,
    input  logic [2:0]        len_log_i,
    output logic [ADDR_W-1:0] nxt_o
);

    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] inc;
    logic [ADDR_W-1:0] low_mask;
    logic [3:0]        blk_log;

    always_comb begin
        step     = ADDR_W'(1) << size_i;
        inc      = cur_i + step;
        blk_log  = {1'b0, len_log_i} + {1'b0, size_i};
        low_mask = ~({ADDR_W{1'b1}} << blk_log);
        if (wrap_i) begin
            nxt_o = (cur_i & ~low_mask) | (inc & low_mask);
        end else begin
            nxt_o = inc;
        end
    end

endmodule

// File: rtl/bt_beat_ctr.sv
module bt_beat_ctr #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_one_i,
    input  logic             clear_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (load_one_i) begin
            cnt_o <= CNT_W'(1);
        end else if (clear_i) begin
            cnt_o <= '0;
        end else if (inc_i && cnt_o != CNT_MAX) begin
            cnt_o <= cnt_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/burst_tracker.sv
module burst_tracker
    import bt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 5     // must be at least 5 to hold a 16-beat count
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              ready_i,
    input  logic [1:0]        trans_i,
    input  logic [2:0]        burst_i,
    input  logic [2:0]        size_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              active_o,
    output logic [CNT_W-1:0]  beats_o,
    output logic [ADDR_W-1:0] next_addr_o,
    output logic              done_o,
    output logic              cut_o,
    output logic              err_o
);

    trk_state_t  state_q, state_d;
    burst_info_t dec_info, info_q;
    logic [2:0]  size_q;
    logic [ADDR_W-1:0] nxt_q, step_base, step_out;
    logic [2:0]  step_size, step_len_log;
    logic        step_wrap;
    logic [CNT_W-1:0] cnt_q, len_cnt;
    logic        done_q, cut_q, err_q;

    xfer_t tt;
    logic  take, is_nseq, is_seq, is_idle, stray_seq;
    logic  last_seq, nseq_single;
    trk_state_t launch_state;

    assign tt        = xfer_t'(trans_i);
    assign take      = sel_i & ready_i;
    assign is_nseq   = take && (tt == TT_NSEQ);
    assign is_idle   = take && (tt == TT_IDLE);
    assign is_seq    = take && (tt == TT_SEQ) && (state_q != ST_OFF);
    assign stray_seq = take && (tt == TT_SEQ) && (state_q == ST_OFF);

    bt_decode u_dec (
        .code_i (burst_i),
        .info_o (dec_info)
    );

    assign len_cnt     = CNT_W'(1) << info_q.len_log;
    assign last_seq    = is_seq && (state_q == ST_FIX) && (cnt_q + CNT_W'(1) == len_cnt);
    assign nseq_single = is_nseq && dec_info.fixed && (dec_info.len_log == 3'd0);

    always_comb begin
        if (!dec_info.fixed) begin
            launch_state = ST_OPEN;
        end else if (dec_info.len_log == 3'd0) begin
            launch_state = ST_OFF;
        end else begin
            launch_state = ST_FIX;
        end
    end

    // address stepping: a launch steps from the bus address, a sequential beat from the expected one
    always_comb begin
        if (is_nseq) begin
            step_base    = addr_i;
            step_size    = size_i;
            step_wrap    = dec_info.wrap;
            step_len_log = dec_info.len_log;
        end else begin
            step_base    = nxt_q;
            step_size    = size_q;
            step_wrap    = info_q.wrap;
            step_len_log = info_q.len_log;
        end
    end

    bt_next_addr #(.ADDR_W(ADDR_W)) u_step (
        .cur_i     (step_base),
        .size_i    (step_size),
        .wrap_i    (step_wrap),
        .len_log_i (step_len_log),
        .nxt_o     (step_out)
    );

    bt_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_one_i (is_nseq),
        .clear_i    (is_idle),
        .inc_i      (is_seq),
        .cnt_o      (cnt_q)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (is_nseq) state_d = launch_state;
            end
            ST_FIX: begin
                if (is_nseq)       state_d = launch_state;
                else if (is_idle)  state_d = ST_OFF;
                else if (last_seq) state_d = ST_OFF;
            end
            ST_OPEN: begin
                if (is_nseq)      state_d = launch_state;
                else if (is_idle) state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs and burst context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            info_q <= '0;
            size_q <= '0;
            nxt_q  <= '0;
            done_q <= 1'b0;
            cut_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= nseq_single | last_seq;
            cut_q  <= (state_q == ST_FIX) && (is_idle || is_nseq);
            err_q  <= stray_seq || (is_seq && (addr_i != nxt_q));
            if (is_nseq) begin
                info_q <= dec_info;
                size_q <= size_i;
                nxt_q  <= step_out;
            end else if (is_seq) begin
                nxt_q  <= step_out;
            end
        end
    end

    assign active_o    = (state_q != ST_OFF);
    assign beats_o     = cnt_q;
    assign next_addr_o = nxt_q;
    assign done_o      = done_q;
    assign cut_o       = cut_q;
    assign err_o       = err_q;

endmodule

// File: rtl/bt_checker.sv
module bt_checker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_i,
    input logic              ready_i,
    input logic [1:0]        trans_i,
    input logic              active_o,
    input logic [CNT_W-1:0]  beats_o,
    input logic [ADDR_W-1:0] next_addr_o,
    input logic              done_o,
    input logic              cut_o,
    input logic              err_o
);

    logic held;
    logic busy_take;
    assign held      = !(sel_i && ready_i);
    assign busy_take = sel_i && ready_i && (trans_i == 2'b01);

    // R2
    hold_when_unsampled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> $stable(beats_o) && $stable(active_o) && $stable(next_addr_o)
                 && !done_o && !cut_o && !err_o);

    // R2
    busy_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_take |=> $stable(beats_o) && $stable(next_addr_o) && !done_o && !cut_o && !err_o);

    // R3
    launch_one_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && ready_i && trans_i == 2'b10) |=> (beats_o == CNT_W'(1)));

    // R6
    done_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !active_o);

    // R7
    cut_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cut_o |-> $past(active_o));

    // R10
    idle_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && ready_i && trans_i == 2'b00) |=> (!active_o && beats_o == '0));

endmodule

bind burst_tracker bt_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_i       (sel_i),
    .ready_i     (ready_i),
    .trans_i     (trans_i),
    .active_o    (active_o),
    .beats_o     (beats_o),
    .next_addr_o (next_addr_o),
    .done_o      (done_o),
    .cut_o       (cut_o),
    .err_o       (err_o)
);

// File: tb/sim_burst_tracker.sv
module sim_burst_tracker;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_i = 1'b0;
    logic          ready_i = 1'b1;
    logic [1:0]    trans_i = 2'b00;
    logic [2:0]    burst_i = 3'b000;
    logic [2:0]    size_i = 3'd0;
    logic [AW-1:0] addr_i = '0;
    logic          active_o, done_o, cut_o, err_o;
    logic [CW-1:0] beats_o;
    logic [AW-1:0] next_addr_o;

    int vecs = 0;
    int fails = 0;

    // bench reference state
    logic          m_active = 1'b0;
    logic          m_fixed = 1'b0;
    logic          m_wrap = 1'b0;
    int            m_len = 0;
    int            m_size = 0;
    int            m_cnt = 0;
    logic [AW-1:0] m_nxt = '0;
    logic          e_done, e_cut, e_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_tracker #(.ADDR_W(AW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .ready_i(ready_i),
        .trans_i(trans_i), .burst_i(burst_i), .size_i(size_i), .addr_i(addr_i),
        .active_o(active_o), .beats_o(beats_o), .next_addr_o(next_addr_o),
        .done_o(done_o), .cut_o(cut_o), .err_o(err_o)
    );

    function automatic logic [AW-1:0] ref_next(input logic [AW-1:0] a);
        longint unsigned stp, blk, base, off;
        stp = longint'(1) << m_size;
        if (m_wrap) begin
            blk  = longint'(m_len) * stp;
            base = longint'(a) - (longint'(a) % blk);
            off  = (longint'(a) - base + stp) % blk;
            return AW'(base + off);
        end
        return AW'(longint'(a) + stp);
    endfunction

    task automatic cmp(input string tag, input string what, input longint act, input longint exp);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        cmp(tag, "active", active_o, m_active);
        cmp(tag, "beats", beats_o, m_cnt);
        cmp(tag, "next_addr", next_addr_o, m_nxt);
        cmp(tag, "done", done_o, e_done);
        cmp(tag, "cut", cut_o, e_cut);
        cmp(tag, "err", err_o, e_err);
    endtask

    task automatic drive(input logic s, input logic r, input logic [1:0] t,
                         input logic [2:0] b, input logic [2:0] z,
                         input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        sel_i = s; ready_i = r; trans_i = t; burst_i = b; size_i = z; addr_i = a;
        e_done = 1'b0; e_cut = 1'b0; e_err = 1'b0;
        if (s && r) begin
            case (t)
                2'b00: begin
                    if (m_active && m_fixed) e_cut = 1'b1;
                    m_active = 1'b0;
                    m_cnt    = 0;
                end
                2'b10: begin
                    if (m_active && m_fixed) e_cut = 1'b1;
                    m_fixed = (b != 3'b001);
                    m_wrap  = (b >= 3'd2) && !b[0];
                    m_len   = (b == 3'b000) ? 1 : (b == 3'b001) ? 0 : (2 << b[2:1]);
                    m_size  = int'(z);
                    m_cnt   = 1;
                    m_nxt   = ref_next(a);
                    if (m_fixed && m_len == 1) begin
                        e_done   = 1'b1;
                        m_active = 1'b0;
                    end else begin
                        m_active = 1'b1;
                    end
                end
                2'b11: begin
                    if (!m_active) begin
                        e_err = 1'b1;
                    end else begin
                        if (a != m_nxt) e_err = 1'b1;
                        if (m_cnt < 31) m_cnt++;
                        m_nxt = ref_next(m_nxt);
                        if (m_fixed && m_cnt == m_len) begin
                            e_done   = 1'b1;
                            m_active = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        check_all(tag);
    endtask

    task automatic gaps(input string tag);
        drive(1'b1, 1'b1, 2'b01, 3'b000, 3'd0, 32'h0, tag);    // busy
        drive(1'b1, 1'b0, 2'b11, 3'b111, 3'd1, 32'hDEAD, tag); // wait state
        drive(1'b0, 1'b1, 2'b10, 3'b011, 3'd2, 32'hBEE0, tag); // not selected
    endtask

    task automatic run_burst(input logic [2:0] code, input int sz, input logic [AW-1:0] start,
                             input bit with_gaps, input string tag);
        logic [AW-1:0] a;
        int n;
        a = start & ~((AW'(1) << sz) - 1);
        drive(1'b1, 1'b1, 2'b10, code, 3'(sz), a, tag);
        n = (code == 3'b001) ? 5 : m_len;
        for (int i = 1; i < n; i++) begin
            if (with_gaps) gaps("R2");
            drive(1'b1, 1'b1, 2'b11, code, 3'(sz), m_nxt, tag);
        end
        drive(1'b1, 1'b1, 2'b00, 3'b000, 3'd0, 32'h0, "R10");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin : stim
        logic [AW-1:0] starts [3];
        starts[0] = 32'h34; starts[1] = 32'h100; starts[2] = 32'h1E6;
        e_done = 1'b0; e_cut = 1'b0; e_err = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check_all("R1");
        @(negedge clk);
        rst_n = 1'b1;

        // all codes, sizes, starts; plain and with busy/wait/deselect gaps
        for (int g = 0; g < 2; g++)
            for (int c = 0; c < 8; c++)
                for (int z = 0; z < 3; z++)
                    for (int s = 0; s < 3; s++)
                        run_burst(3'(c), z, starts[s], g != 0,
                                  (c >= 2 && c[0] == 1'b0) ? "R5" : (c == 1 ? "R8" : "R4"));

        // R6: single transfers back to back
        for (int k = 0; k < 4; k++)
            drive(1'b1, 1'b1, 2'b10, 3'b000, 3'd2, AW'(32'h200 + 4*k), "R6");

        // R7: cut after every beat position of every fixed burst
        for (int c = 2; c < 8; c++) begin
            int len;
            len = 2 << (c >> 1);
            for (int k = 1; k < len; k++) begin
                drive(1'b1, 1'b1, 2'b10, 3'(c), 3'd2, 32'h3C, "R7");
                for (int i = 1; i < k; i++)
                    drive(1'b1, 1'b1, 2'b11, 3'(c), 3'd2, m_nxt, "R7");
                if (k % 2 == 1)
                    drive(1'b1, 1'b1, 2'b00, 3'b000, 3'd0, 32'h0, "R7");
                else begin
                    drive(1'b1, 1'b1, 2'b10, 3'b011, 3'd1, 32'h80, "R7");
                    drive(1'b1, 1'b1, 2'b00, 3'b000, 3'd0, 32'h0, "R10");
                end
            end
        end

        // R8: unspecified-length bursts of 1..4 beats, ended by idle or new burst
        for (int n = 1; n <= 4; n++) begin
            drive(1'b1, 1'b1, 2'b10, 3'b001, 3'd1, AW'(32'h20 * n), "R8");
            for (int i = 1; i < n; i++)
                drive(1'b1, 1'b1, 2'b11, 3'b001, 3'd1, m_nxt, "R8");
            if (n % 2 == 0)
                drive(1'b1, 1'b1, 2'b00, 3'b000, 3'd0, 32'h0, "R8");
            else
                drive(1'b1, 1'b1, 2'b10, 3'b001, 3'd2, 32'h5C, "R8");
        end
        drive(1'b1, 1'b1, 2'b00, 3'b000, 3'd0, 32'h0, "R10");

        // R9: bad address inside a burst, then a stray sequential beat
        drive(1'b1, 1'b1, 2'b10, 3'b011, 3'd2, 32'h40, "R9");
        drive(1'b1, 1'b1, 2'b11, 3'b011, 3'd2, 32'h48, "R9");
        drive(1'b1, 1'b1, 2'b11, 3'b011, 3'd2, m_nxt, "R9");
        drive(1'b1, 1'b1, 2'b00, 3'b000, 3'd0, 32'h0, "R10");
        drive(1'b1, 1'b1, 2'b11, 3'b011, 3'd2, 32'h44, "R9");

        // R11: long unspecified burst saturates the counter
        drive(1'b1, 1'b1, 2'b10, 3'b001, 3'd0, 32'h0, "R11");
        for (int i = 0; i < 40; i++)
            drive(1'b1, 1'b1, 2'b11, 3'b001, 3'd0, m_nxt, "R11");
        drive(1'b1, 1'b1, 2'b00, 3'b000, 3'd0, 32'h0, "R10");

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule